// File: doc/BRIEF.md
# I2S Receive Channel

This block is the receive half of an I2S port. It runs on the external serial bit clock. Word select (WS) frames the stream: a low WS phase carries a left sample and a high WS phase carries a right sample. A bit counter, bounded by the selected sample width, collects the serial data of each phase MSB first.

When WS next changes, the finished sample moves into a left or right hold register. Complete samples are then packed into 32-bit words, which go out on a receive FIFO write strobe. The widths are 8, 16 and 32 bits, each in stereo or mono.

A synchronous reset brings the channel back to a known framing state. Software asserts it around any change of width or mode. A full FIFO drops the word and raises a sticky overrun flag.

Top module: `i2s_rx_top`

## Requirements
- R1: The level of WS sampled on a rising bit-clock edge picks the channel: 0 is left, 1 is right. The rising edge that sees a WS change starts a new phase and captures no data. The MSB is sampled on the next rising edge, and the remaining bits follow MSB first.
- R2: Each phase captures at most width bits. Serial data after the bit counter reaches the limit is ignored.
- R3: width_sel selects the sample width: 0 gives 8 bits, 1 gives 16 bits, 3 gives 32 bits. Code 2 behaves like 3.
- R4: Stereo 32-bit mode writes two words per frame, left first, then right in the following cycle. Both words are released by the WS change that ends the right phase.
- R5: Stereo 16-bit mode writes one word per frame: left in [15:0] and right in [31:16].
- R6: Stereo 8-bit mode writes one word per two frames. Bytes 0 to 3 hold L(n), R(n), L(n+1), R(n+1).
- R7: With mono=1 only left (WS low) samples are used. They are packed four per word in 8-bit mode (first in byte 0), two per word in 16-bit mode (first in [15:0]) and one per word in 32-bit mode. Right-phase data produces no write.
- R8: fifo_wr pulses for one cycle, and only once a full 32-bit word exists. It is high in the cycle that follows the rising edge at which the completing WS change is sampled.
- R9: A phase that ends before the width limit is reached yields its captured bits right-aligned, with the upper bits zero.
- R10: The first WS change after reset only starts capture and commits nothing. In stereo modes a right sample with no left sample before it in the same frame is discarded.
- R11: When fifo_full is high while a word is due, fifo_wr stays low, the word is lost and overrun goes high. Overrun stays high until reset.
- R12: rst, sampled on a rising edge, clears the bit counter, the hold registers, any partly packed word, the overrun flag and the framing state. fifo_wr is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select: 0 left phase, 1 right phase |
| sd | input | 1 | Serial data, MSB first |
| width_sel | input | 2 | Sample width code (0: 8, 1: 16, 3: 32 bits) |
| mono | input | 1 | 1: pack left samples only |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| fifo_data | output | 32 | Word written to the FIFO |
| overrun | output | 1 | Sticky flag: a word was dropped on a full FIFO |

## Verification
A committed sample is due one cycle after the rising edge that samples the WS change. In 32-bit stereo the right word follows one cycle after the left word. The bench drives WS and data on falling edges and records fifo_wr and fifo_data on every falling edge, so each write is caught halfway through the cycle in which it is due. A directed test checks that the strobe is low on the falling edge before the WS change is sampled and high on the falling edge right after it. The stimulus table and the other directed tests always append a trailing WS phase and several idle cycles, so the last expected word has time to land before the collected words are compared.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int POS_W  = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        WID_8    = 2'd0,
        WID_16   = 2'd1,
        WID_RSVD = 2'd2,
        WID_32   = 2'd3
    } width_e;

    typedef struct packed {
        logic              valid;
        logic              side;   // 0 left, 1 right
        logic [WORD_W-1:0] value;
    } sample_t;

    function automatic logic [CNT_W-1:0] width_bits(width_e w);
        case (w)
            WID_8:   return CNT_W'(LANE_W);
            WID_16:  return CNT_W'(2 * LANE_W);
            default: return CNT_W'(WORD_W);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] sample_lanes(width_e w);
        case (w)
            WID_8:   return POS_W'(1);
            WID_16:  return POS_W'(2);
            default: return POS_W'(LANES);
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_capture.sv
module i2s_rx_capture
    import i2s_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ws,
    input  logic    sd,
    input  width_e  width,
    output sample_t commit
);

    logic              ws_q;
    logic              seen;
    logic              armed;
    logic              change;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  limit;
    logic [WORD_W-1:0] shreg;

    assign limit  = width_bits(width);
    assign change = seen && (ws != ws_q);

    always_comb begin
        commit.valid = change && armed;
        commit.side  = ws_q;
        commit.value = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q  <= 1'b0;
            seen  <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            ws_q <= ws;
            seen <= 1'b1;
            if (change) begin
                armed <= 1'b1;
                cnt   <= '0;
                shreg <= '0;
            end else if (armed && (cnt < limit)) begin
                shreg <= {shreg[WORD_W-2:0], sd};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // R2: once the limit is reached the shift register is frozen
    a_r2_stop_at_limit: assert property (@(posedge clk) disable iff (rst)
        (armed && !change && (cnt >= limit)) |=> $stable(shreg));

    // R1: a commit is always followed by a freshly restarted phase
    a_r1_phase_restart: assert property (@(posedge clk) disable iff (rst)
        commit.valid |=> (armed && (shreg == '0)));

endmodule

// File: rtl/i2s_rx_pack.sv
module i2s_rx_pack
    import i2s_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sample_t           commit,
    input  width_e            width,
    input  logic              mono,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    logic [WORD_W-1:0] hold_l, hold_r, acc;
    logic              l_valid, pend_r;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  nb;
    logic              app_en;
    logic [WORD_W-1:0] app_data, acc_sum;
    logic [POS_W-1:0]  app_lanes, pos_sum;
    logic              pair_done, mono_left;

    assign nb        = sample_lanes(width);
    assign mono_left = commit.valid && mono && !commit.side;
    assign pair_done = commit.valid && !mono && commit.side && l_valid;

    always_comb begin
        app_en    = 1'b0;
        app_data  = '0;
        app_lanes = '0;
        if (mono_left && (nb != POS_W'(LANES))) begin
            app_en    = 1'b1;
            app_data  = commit.value;
            app_lanes = nb;
        end else if (pair_done && (nb == POS_W'(1))) begin
            app_en    = 1'b1;
            app_data  = {{(WORD_W-2*LANE_W){1'b0}},
                         commit.value[LANE_W-1:0], hold_l[LANE_W-1:0]};
            app_lanes = POS_W'(2);
        end
        acc_sum = acc | (app_data << (pos * LANE_W));
        pos_sum = pos + app_lanes;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l     <= '0;
            hold_r     <= '0;
            acc        <= '0;
            pos        <= '0;
            l_valid    <= 1'b0;
            pend_r     <= 1'b0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (pend_r) begin
                word_valid <= 1'b1;
                word_data  <= hold_r;
                pend_r     <= 1'b0;
            end
            if (commit.valid) begin
                if (!commit.side) begin
                    hold_l  <= commit.value;
                    l_valid <= !mono;
                end else begin
                    hold_r  <= commit.value;
                    l_valid <= 1'b0;
                end
            end
            if (mono_left && (nb == POS_W'(LANES))) begin
                word_valid <= 1'b1;
                word_data  <= commit.value;
            end
            if (pair_done && (nb == POS_W'(LANES))) begin
                word_valid <= 1'b1;
                word_data  <= hold_l;
                pend_r     <= 1'b1;
            end
            if (pair_done && (nb == POS_W'(2))) begin
                word_valid <= 1'b1;
                word_data  <= {commit.value[2*LANE_W-1:0], hold_l[2*LANE_W-1:0]};
            end
            if (app_en) begin
                if (pos_sum == POS_W'(LANES)) begin
                    word_valid <= 1'b1;
                    word_data  <= acc_sum;
                    acc        <= '0;
                    pos        <= '0;
                end else begin
                    acc <= acc_sum;
                    pos <= pos_sum;
                end
            end
        end
    end

    // R4: the right word of a 32-bit pair follows the left word at once
    a_r4_right_follows: assert property (@(posedge clk) disable iff (rst)
        pend_r |=> word_valid);

    // R8: a word only appears as the result of a commit or a pending right word
    a_r8_write_has_cause: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(commit.valid || pend_r));

    // R7: in mono a right-phase commit never produces a word
    a_r7_mono_right_silent: assert property (@(posedge clk) disable iff (rst)
        (mono && commit.valid && commit.side && !pend_r) |=> !word_valid);

endmodule

// File: rtl/i2s_rx_wrport.sv
module i2s_rx_wrport
    import i2s_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overrun
);

    assign fifo_wr   = word_valid && !fifo_full;
    assign fifo_data = word_data;

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (word_valid && fifo_full)
            overrun <= 1'b1;
    end

    // R11: a dropped word raises the flag on the next edge
    a_r11_flag_on_drop: assert property (@(posedge clk) disable iff (rst)
        (word_valid && fifo_full) |=> overrun);

    // R11: the flag is sticky until reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/i2s_rx_top.sv
module i2s_rx_top
    import i2s_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ws,
    input  logic              sd,
    input  logic [1:0]        width_sel,
    input  logic              mono,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overrun
);

    width_e            width;
    sample_t           commit;
    logic              word_valid;
    logic [WORD_W-1:0] word_data;

    assign width = width_e'(width_sel);

    i2s_rx_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .ws     (ws),
        .sd     (sd),
        .width  (width),
        .commit (commit)
    );

    i2s_rx_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .width      (width),
        .mono       (mono),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    i2s_rx_wrport u_wrport (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_data  (word_data),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .overrun    (overrun)
    );

    // R12: no write strobe in the cycle after a reset edge
    a_r12_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !fifo_wr);

endmodule

// File: tb/sim_i2s_rx_top.sv
`timescale 1ns/1ps
module sim_i2s_rx_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [1:0]  width_sel = 2'd3;
    logic        mono = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_data;
    logic        overrun;

    int nchk = 0;
    int nfail = 0;
    int ngot = 0;
    logic [31:0] got [0:63];

    always #10 clk = ~clk;

    i2s_rx_top u0 (
        .clk(clk), .rst(rst), .ws(ws), .sd(sd), .width_sel(width_sel),
        .mono(mono), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .overrun(overrun)
    );

    // write collector: samples mid-cycle
    always @(negedge clk) begin
        if (fifo_wr === 1'b1 && ngot < 64) begin
            got[ngot] = fifo_data;
            ngot = ngot + 1;
        end
    end

    // width(2) mono(1) extra(4) seed(32)
    localparam logic [38:0] VEC [0:7] = '{
        {2'd3, 1'b0, 4'd0, 32'hA5C3_1E27},
        {2'd1, 1'b0, 4'd3, 32'h1234_8765},
        {2'd0, 1'b0, 4'd2, 32'h00C3_00F1},
        {2'd3, 1'b1, 4'd0, 32'h9E37_79B9},
        {2'd1, 1'b1, 4'd5, 32'hDEAD_BEEF},
        {2'd0, 1'b1, 4'd1, 32'h0F1E_2D3C},
        {2'd2, 1'b0, 4'd1, 32'h7777_1111},
        {2'd0, 1'b0, 4'd7, 32'hC001_D00D}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    task automatic cyc(input logic w, input logic d);
        @(negedge clk);
        ws = w;
        sd = d;
    endtask

    // one WS phase: change slot, nb data bits MSB first, extra junk ones
    task automatic phase(input logic w, input logic [31:0] v, input int nb, input int extra);
        cyc(w, 1'b1);
        for (int i = nb - 1; i >= 0; i--) cyc(w, v[i]);
        for (int i = 0; i < extra; i++) cyc(w, 1'b1);
    endtask

    task automatic do_reset(input logic init_ws);
        @(negedge clk);
        rst = 1'b1;
        ws = init_ws;
        sd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int nbits(input logic [1:0] w);
        if (w == 2'd0) return 8;
        if (w == 2'd1) return 16;
        return 32;
    endfunction

    function automatic logic [31:0] msk(input int n);
        if (n == 32) return 32'hFFFF_FFFF;
        return (32'd1 << n) - 32'd1;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=running exp=done");
        report();
        $finish;
    end

    initial begin : main
        logic [1:0]  vw;
        logic        vm;
        int          vx, n, base, nexp, pos;
        logic [31:0] vs, lv, rv, acc;
        logic [31:0] exp [0:15];
        string       tag;

        // table-driven stream tests
        for (int k = 0; k < 8; k++) begin
            vw = VEC[k][38:37];
            vm = VEC[k][36];
            vx = int'(VEC[k][35:32]);
            vs = VEC[k][31:0];
            n  = nbits(vw);
            if (vw == 2'd2)      tag = "R3";
            else if (vm)         tag = "R7";
            else if (n == 32)    tag = "R4";
            else if (n == 16)    tag = "R5";
            else                 tag = "R6";
            if (vx != 0) tag = {tag, " R2"};
            tag = {tag, " R1"};
            width_sel = vw;
            mono = vm;
            do_reset(1'b1);
            base = ngot;
            nexp = 0;
            acc = '0;
            pos = 0;
            for (int f = 0; f < 4; f++) begin
                lv = (vs * 32'(f + 3)) & msk(n);
                rv = (vs ^ (32'h5A5A_0000 + 32'(f) * 32'h0000_0111)) & msk(n);
                phase(1'b0, lv, n, vx);
                phase(1'b1, rv, n, vx);
                if (vm) begin
                    if (n == 32) begin
                        exp[nexp] = lv; nexp++;
                    end else begin
                        acc = acc | (lv << (pos * 8));
                        pos = pos + n / 8;
                        if (pos == 4) begin exp[nexp] = acc; nexp++; acc = '0; pos = 0; end
                    end
                end else begin
                    if (n == 32) begin
                        exp[nexp] = lv; nexp++;
                        exp[nexp] = rv; nexp++;
                    end else begin
                        acc = acc | (((rv << n) | lv) << (pos * 8));
                        pos = pos + 2 * n / 8;
                        if (pos == 4) begin exp[nexp] = acc; nexp++; acc = '0; pos = 0; end
                    end
                end
            end
            phase(1'b0, 32'h0, n, 0);
            repeat (3) cyc(1'b0, 1'b0);
            chk({tag, " R8 count"}, 32'(ngot - base), 32'(nexp));
            for (int i = 0; i < nexp; i++)
                chk(tag, (base + i < 64) ? got[base + i] : 32'hDEAD_DEAD, exp[i]);
        end

        // R12: reset state
        width_sel = 2'd1; mono = 1'b0;
        do_reset(1'b1);
        chk("R12 fifo_wr after reset", 32'(fifo_wr), 32'd0);
        chk("R12 overrun after reset", 32'(overrun), 32'd0);

        // R8: write strobe timing, stereo 16
        phase(1'b0, 32'h0000_1357, 16, 0);
        phase(1'b1, 32'h0000_9BDF, 16, 0);
        @(negedge clk);
        chk("R8 no early write", 32'(fifo_wr), 32'd0);
        ws = 1'b0; sd = 1'b1;
        @(negedge clk);
        chk("R8 write strobe due", 32'(fifo_wr), 32'd1);
        chk("R8 R5 write data", fifo_data, 32'h9BDF_1357);
        @(negedge clk);
        chk("R8 single pulse", 32'(fifo_wr), 32'd0);

        // R10: first change only arms; orphan right sample discarded
        width_sel = 2'd1; mono = 1'b0;
        do_reset(1'b0);
        base = ngot;
        phase(1'b1, 32'h0000_AAAA, 16, 0);
        phase(1'b0, 32'h0000_4321, 16, 0);
        phase(1'b1, 32'h0000_8765, 16, 0);
        phase(1'b0, 32'h0, 16, 0);
        repeat (3) cyc(1'b0, 1'b0);
        chk("R10 word count", 32'(ngot - base), 32'd1);
        chk("R10 word data", got[base], 32'h8765_4321);

        // R9: short phase is zero-filled
        width_sel = 2'd3; mono = 1'b0;
        do_reset(1'b1);
        base = ngot;
        phase(1'b0, 32'h0000_00A5, 8, 0);
        phase(1'b1, 32'h8000_0001, 32, 0);
        phase(1'b0, 32'h0, 4, 0);
        repeat (3) cyc(1'b0, 1'b0);
        chk("R9 R4 word count", 32'(ngot - base), 32'd2);
        chk("R9 partial left", got[base], 32'h0000_00A5);
        chk("R4 right second", got[base + 1], 32'h8000_0001);

        // R11: full FIFO drops the word, flag is sticky
        width_sel = 2'd3; mono = 1'b1;
        do_reset(1'b1);
        base = ngot;
        fifo_full = 1'b1;
        phase(1'b0, 32'h1111_2222, 32, 0);
        phase(1'b1, 32'h3333_4444, 32, 0);
        fifo_full = 1'b0;
        chk("R11 dropped word", 32'(ngot - base), 32'd0);
        chk("R11 overrun set", 32'(overrun), 32'd1);
        phase(1'b0, 32'h5555_6666, 32, 0);
        phase(1'b1, 32'h0, 32, 0);
        repeat (2) cyc(1'b0, 1'b0);
        chk("R11 write resumes", 32'(ngot - base), 32'd1);
        chk("R11 R7 resumed data", got[base], 32'h5555_6666);
        chk("R11 overrun sticky", 32'(overrun), 32'd1);
        do_reset(1'b1);
        chk("R12 overrun cleared", 32'(overrun), 32'd0);

        // R12: reset discards partly packed mono 8-bit word
        width_sel = 2'd0; mono = 1'b1;
        do_reset(1'b1);
        phase(1'b0, 32'h11, 8, 0);
        phase(1'b1, 32'hEE, 8, 0);
        phase(1'b0, 32'h22, 8, 0);
        phase(1'b1, 32'hEE, 8, 0);
        do_reset(1'b1);
        base = ngot;
        for (int f = 0; f < 4; f++) begin
            phase(1'b0, 32'(8'h33 + 8'(f) * 8'h11), 8, 0);
            phase(1'b1, 32'hFF, 8, 0);
        end
        repeat (3) cyc(1'b1, 1'b0);
        chk("R12 R7 count after reset", 32'(ngot - base), 32'd1);
        chk("R12 R7 fresh word", got[base], 32'h6655_4433);

        report();
        $finish;
    end

endmodule